// File: doc/BRIEF.md
# Operand Offset Former for Register-Indirect Addressing

This block turns the addressing byte of a 16-bit two-operand instruction into the operand's offset within its segment. It takes the addressing byte, up to two displacement bytes and the present contents of the two base registers (BX, BP) and two index registers (SI, DI). From these it works out three things: the 16-bit offset, the segment that should be used by default, and whether the byte names a register rather than memory. An optional segment override replaces the default segment.

The caller presents all inputs and pulses `start` for one cycle. On the next clock edge the results are captured, and `done` is high for exactly that one cycle. The captured outputs then stay unchanged until the next `start`. The block forms no physical address and does not touch memory.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and after it is released, and before any start, `done` is 0, `offset` is 0, `seg` is 2'b11 (DS) and `is_reg` is 0.
- R2: `done` is 1 in exactly the cycle after each cycle in which `start` was sampled high, including consecutive starts. `offset`, `seg` and `is_reg` update only on those edges and hold their values otherwise.
- R3: Bits [2:0] of `modrm` select the base and index. Codes 000, 001, 010 and 011 select BX+SI, BX+DI, BP+SI and BP+DI respectively, each plus the displacement.
- R4: Codes 100, 101, 110 and 111 select SI, DI, BP and BX respectively, each plus the displacement. The one exception to code 110 is given in R7.
- R5: With mode bits `modrm[7:6]` = 01, the displacement is `disp_lo` sign-extended to 16 bits, and `disp_hi` has no effect on `offset`.
- R6: With mode 10, the displacement is {`disp_hi`,`disp_lo`}.
- R7: With mode 00 the displacement is zero, except when the r/m code is 110. In that case `offset` is {`disp_hi`,`disp_lo`} and no register contributes.
- R8: All additions wrap modulo 2^16.
- R9: Forms that use BP (r/m 010 and 011 in any memory mode, and r/m 110 outside mode 00) give a default segment of SS (2'b10). All other memory forms, including the direct address, give DS (2'b11).
- R10: Segment codes are 00 ES, 01 CS, 10 SS and 11 DS. When `ovr_valid` is high in a memory form, `seg` becomes `ovr_seg` in place of the default.
- R11: Mode 11 gives `is_reg`=1, `offset`=0 and `seg`=2'b11, whatever the override inputs are. Memory forms give `is_reg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture request for the current inputs |
| modrm | input | 8 | Addressing byte: mode [7:6], reg [5:3], r/m [2:0] |
| disp_lo | input | 8 | Low displacement byte |
| disp_hi | input | 8 | High displacement byte |
| bx | input | 16 | BX value |
| bp | input | 16 | BP value |
| si | input | 16 | SI value |
| di | input | 16 | DI value |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| done | output | 1 | One-cycle result strobe |
| offset | output | 16 | Effective offset |
| seg | output | 2 | Segment to use |
| is_reg | output | 1 | Operand is a register |

## Verification
The hardest case to reach is r/m code 110, because it behaves in three ways. In mode 00 it is a direct address with DS and BP ignored. In modes 01 and 10 it is BP-based with SS. In mode 11 it names a register. The stimulus runs the same code 110 through every mode, with BP set to a conspicuous value and the displacement bytes set to values that differ from it, so that any leak of BP or any wrong default segment shows up at the outputs. Wrap-around and sign extension are reached with all-ones register values and a displacement byte of 0x80 or above. Back-to-back starts and idle cycles with changing inputs check the capture timing.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_W   = 16;
  localparam int BYTE_W = EA_W / 2;

  typedef logic [EA_W-1:0]   word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_e;

  localparam logic [1:0] MD_NONE  = 2'b00;
  localparam logic [1:0] MD_DISP8 = 2'b01;
  localparam logic [1:0] MD_DISP16 = 2'b10;
  localparam logic [1:0] MD_REG   = 2'b11;

  // absolute-address escape: no-displacement mode with the BP-only code
  function automatic logic is_direct(input logic [1:0] md, input logic [2:0] rm);
    return (md == MD_NONE) && (rm == 3'b110);
  endfunction

  function automatic word_t disp_value(input logic [1:0] md, input logic [2:0] rm,
                                       input byte_t lo, input byte_t hi);
    word_t d;
    case (md)
      MD_DISP8:  d = {{BYTE_W{lo[BYTE_W-1]}}, lo};
      MD_DISP16: d = {hi, lo};
      MD_NONE:   d = is_direct(md, rm) ? {hi, lo} : '0;
      default:   d = '0;
    endcase
    return d;
  endfunction

  function automatic logic bp_based(input logic [1:0] md, input logic [2:0] rm);
    return (md != MD_REG) && !is_direct(md, rm) &&
           ((rm == 3'b010) || (rm == 3'b011) || (rm == 3'b110));
  endfunction
endpackage

// File: rtl/ea_disp_sel.sv
module ea_disp_sel
  import ea_pkg::*;
(
  input  logic [1:0] md,
  input  logic [2:0] rm,
  input  byte_t      lo,
  input  byte_t      hi,
  output word_t      disp,
  output logic       direct
);
  always_comb begin
    disp   = disp_value(md, rm, lo, hi);
    direct = is_direct(md, rm);
  end
endmodule

// File: rtl/ea_base_sel.sv
module ea_base_sel
  import ea_pkg::*;
(
  input  logic [2:0] rm,
  input  logic       direct,
  input  word_t      bx,
  input  word_t      bp,
  input  word_t      si,
  input  word_t      di,
  output word_t      base_sum
);
  word_t pair_sum;
  word_t single;

  always_comb begin
    pair_sum = (rm[1] ? bp : bx) + (rm[0] ? di : si);
    case (rm[1:0])
      2'b00:   single = si;
      2'b01:   single = di;
      2'b10:   single = direct ? '0 : bp;
      default: single = bx;
    endcase
    base_sum = rm[2] ? single : pair_sum;
  end
endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
  import ea_pkg::*;
(
  input  logic       uses_bp,
  input  logic       reg_form,
  input  logic       ovr_valid,
  input  logic [1:0] ovr_seg,
  output seg_e       seg_sel
);
  always_comb begin
    if (reg_form)       seg_sel = SEG_DS;
    else if (ovr_valid) seg_sel = seg_e'(ovr_seg);
    else if (uses_bp)   seg_sel = SEG_SS;
    else                seg_sel = SEG_DS;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       modrm,
  input  logic [BYTE_W-1:0] disp_lo,
  input  logic [BYTE_W-1:0] disp_hi,
  input  logic [EA_W-1:0]  bx,
  input  logic [EA_W-1:0]  bp,
  input  logic [EA_W-1:0]  si,
  input  logic [EA_W-1:0]  di,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_seg,
  output logic             done,
  output logic [EA_W-1:0]  offset,
  output logic [1:0]       seg,
  output logic             is_reg
);
  logic [1:0] md;
  logic [2:0] rm;
  word_t      disp;
  logic       direct;
  word_t      base_sum;
  word_t      ea_sum;
  logic       reg_form;
  logic       uses_bp;
  seg_e       seg_sel;

  assign md       = modrm[7:6];
  assign rm       = modrm[2:0];
  assign reg_form = (md == MD_REG);
  assign uses_bp  = bp_based(md, rm);

  ea_disp_sel u_disp (
    .md(md), .rm(rm), .lo(disp_lo), .hi(disp_hi), .disp(disp), .direct(direct)
  );

  ea_base_sel u_base (
    .rm(rm), .direct(direct), .bx(bx), .bp(bp), .si(si), .di(di), .base_sum(base_sum)
  );

  ea_seg_pick u_seg (
    .uses_bp(uses_bp), .reg_form(reg_form), .ovr_valid(ovr_valid),
    .ovr_seg(ovr_seg), .seg_sel(seg_sel)
  );

  assign ea_sum = base_sum + disp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      offset <= '0;
      seg    <= SEG_DS;
      is_reg <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        offset <= reg_form ? '0 : ea_sum;
        seg    <= seg_sel;
        is_reg <= reg_form;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [7:0]  modrm,
  input logic [7:0]  disp_lo,
  input logic [7:0]  disp_hi,
  input logic        ovr_valid,
  input logic [1:0]  ovr_seg,
  input logic        done,
  input logic [15:0] offset,
  input logic [1:0]  seg,
  input logic        is_reg,
  input logic        uses_bp
);
  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(offset) && $stable(seg) && $stable(is_reg)));
  p_direct_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b110)
      |=> (offset == {$past(disp_hi), $past(disp_lo)} && seg == 2'b11 + 2'b00 * {1'b0, $past(ovr_valid)}
           || $past(ovr_valid)));
  p_stack_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && uses_bp && !ovr_valid) |=> seg == 2'b10);
  p_override_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ovr_valid && modrm[7:6] != 2'b11) |=> seg == $past(ovr_seg));
  p_reg_form_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && modrm[7:6] == 2'b11) |=> (is_reg && offset == 16'h0 && seg == 2'b11));
  p_mem_form_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && modrm[7:6] != 2'b11) |=> !is_reg);
endmodule

bind ea_gen ea_gen_chk u_ea_gen_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .modrm(modrm),
  .disp_lo(disp_lo), .disp_hi(disp_hi), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
  .done(done), .offset(offset), .seg(seg), .is_reg(is_reg), .uses_bp(uses_bp)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  modrm = '0;
  logic [7:0]  disp_lo = '0;
  logic [7:0]  disp_hi = '0;
  logic [15:0] bx = '0, bp = '0, si = '0, di = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_seg = '0;
  logic        done;
  logic [15:0] offset;
  logic [1:0]  seg;
  logic        is_reg;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] off;
    logic [1:0]  sg;
    logic        rg;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t last;

  always #2 clk = ~clk;  // 250 MHz

  ea_gen i_ea_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .modrm(modrm),
    .disp_lo(disp_lo), .disp_hi(disp_hi), .bx(bx), .bp(bp), .si(si), .di(di),
    .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .done(done), .offset(offset), .seg(seg), .is_reg(is_reg)
  );

  // independent model written from the requirements
  function automatic exp_t model(input string tag);
    exp_t e;
    int   d;
    int   s;
    bit   stack;
    e.tag = tag;
    if (modrm[7:6] == 2'd3) begin  // R11
      e.off = 16'h0; e.sg = 2'b11; e.rg = 1'b1;
      return e;
    end
    case (modrm[7:6])
      2'd1:    d = int'($signed(disp_lo));          // R5
      2'd2:    d = int'(disp_hi) * 256 + int'(disp_lo);  // R6
      default: d = 0;                               // R7
    endcase
    stack = 1'b0;
    case (modrm[2:0])
      3'd0: s = int'(bx) + int'(si);
      3'd1: s = int'(bx) + int'(di);
      3'd2: begin s = int'(bp) + int'(si); stack = 1'b1; end
      3'd3: begin s = int'(bp) + int'(di); stack = 1'b1; end
      3'd4: s = int'(si);
      3'd5: s = int'(di);
      3'd6: if (modrm[7:6] == 2'd0) s = int'(disp_hi) * 256 + int'(disp_lo);
            else begin s = int'(bp); stack = 1'b1; end
      default: s = int'(bx);
    endcase
    s = (s + d) & 32'hFFFF;  // R8
    e.off = s[15:0];
    e.sg  = ovr_valid ? ovr_seg : (stack ? 2'b10 : 2'b11);  // R9 R10
    e.rg  = 1'b0;
    return e;
  endfunction

  task automatic fail_line(input string tag, input string what, input int act, input int exp_v);
    n_fail++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
  endtask

  // driver: present a vector and raise start for one cycle
  task automatic issue(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi,
                       input logic [15:0] vbx, input logic [15:0] vbp,
                       input logic [15:0] vsi, input logic [15:0] vdi,
                       input logic ov, input logic [1:0] os, input string tag);
    @(negedge clk);
    modrm = m; disp_lo = lo; disp_hi = hi;
    bx = vbx; bp = vbp; si = vsi; di = vdi;
    ovr_valid = ov; ovr_seg = os;
    start = 1'b1;
    sb.push_back(model(tag));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start = 1'b0;
      modrm = modrm ^ 8'h5A; bx = ~bx; disp_lo = disp_lo + 8'd3;
      ovr_valid = ~ovr_valid;
    end
  endtask

  // monitor: compare after every edge
  initial begin
    last.off = 16'h0; last.sg = 2'b11; last.rg = 1'b0; last.tag = "R2 hold";
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && !finished) begin
        if (done) begin
          n_checks++;
          if (sb.size() == 0) begin
            fail_line("R2", "done without start", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            if (offset !== e.off) fail_line(e.tag, "offset", int'(offset), int'(e.off));
            else if (seg !== e.sg) fail_line(e.tag, "seg", int'(seg), int'(e.sg));
            else if (is_reg !== e.rg) fail_line(e.tag, "is_reg", int'(is_reg), int'(e.rg));
            last = e;
          end
        end else if (sb.size() == 0) begin
          n_checks++;  // R2: outputs hold while idle
          if (offset !== last.off || seg !== last.sg || is_reg !== last.rg)
            fail_line("R2", "hold offset", int'(offset), int'(last.off));
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;  // R1 during reset
    if (done !== 1'b0 || offset !== 16'h0 || seg !== 2'b11 || is_reg !== 1'b0)
      fail_line("R1", "reset outputs", int'({done, offset, seg, is_reg}), int'({1'b0, 16'h0, 2'b11, 1'b0}));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_checks++;  // R1 after release
    if (done !== 1'b0 || offset !== 16'h0 || seg !== 2'b11 || is_reg !== 1'b0)
      fail_line("R1", "post-reset outputs", int'({done, offset, seg, is_reg}), int'({1'b0, 16'h0, 2'b11, 1'b0}));

    // R3 pairs, R4 singles, each mode
    for (int md = 0; md < 3; md++)
      for (int r = 0; r < 8; r++)
        issue({md[1:0], 3'b000, r[2:0]}, 8'h34, 8'h12, 16'h1000, 16'h2000,
              16'h0300, 16'h0040, 1'b0, 2'b00, (r < 4) ? "R3" : "R4");
    idle(2);
    // R7 direct address: BP and override-free, BP must not leak
    issue(8'b00_000_110, 8'hCD, 8'hAB, 16'h1111, 16'h7777, 16'h2222, 16'h3333, 1'b0, 2'b00, "R7");
    idle(1);
    issue(8'b01_000_110, 8'h10, 8'hAB, 16'h1111, 16'h7777, 16'h2222, 16'h3333, 1'b0, 2'b00, "R9");
    issue(8'b10_000_110, 8'hCD, 8'hAB, 16'h1111, 16'h7777, 16'h2222, 16'h3333, 1'b0, 2'b00, "R6");
    issue(8'b11_000_110, 8'hCD, 8'hAB, 16'h1111, 16'h7777, 16'h2222, 16'h3333, 1'b1, 2'b01, "R11");
    idle(2);
    // R5 sign extension, disp_hi must not matter
    issue(8'b01_000_100, 8'h80, 8'h55, 16'h0, 16'h0, 16'h0100, 16'h0, 1'b0, 2'b00, "R5");
    issue(8'b01_000_101, 8'h7F, 8'hFF, 16'h0, 16'h0, 16'h0, 16'h0100, 1'b0, 2'b00, "R5");
    // R8 wrap
    issue(8'b00_000_000, 8'h00, 8'h00, 16'hFFFF, 16'h0, 16'h0002, 16'h0, 1'b0, 2'b00, "R8");
    issue(8'b10_000_011, 8'hFF, 8'hFF, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF, 1'b0, 2'b00, "R8");
    issue(8'b01_000_111, 8'hFE, 8'h00, 16'h0001, 16'h0, 16'h0, 16'h0, 1'b0, 2'b00, "R8");
    idle(3);
    // R10 every override code on a stack form and a data form
    for (int o = 0; o < 4; o++) begin
      issue(8'b01_000_010, 8'h04, 8'h00, 16'h10, 16'h20, 16'h30, 16'h40, 1'b1, o[1:0], "R10");
      issue(8'b00_000_111, 8'h00, 8'h00, 16'h10, 16'h20, 16'h30, 16'h40, 1'b1, o[1:0], "R10");
    end
    idle(2);
    // R9 default segments across all memory forms
    for (int md = 0; md < 3; md++)
      for (int r = 0; r < 8; r++)
        issue({md[1:0], 3'b101, r[2:0]}, 8'h01, 8'h02, 16'hA000, 16'hB000,
              16'h0C00, 16'h00D0, 1'b0, 2'b10, "R9");
    idle(1);
    // R11 register forms with overrides present
    for (int r = 0; r < 8; r++)
      issue({2'b11, 3'b010, r[2:0]}, 8'hEE, 8'hDD, 16'h1, 16'h2, 16'h3, 16'h4, 1'b1, 2'b00, "R11");
    idle(2);
    // mixed random patterns, occasional idle gaps (R2)
    for (int k = 0; k < 300; k++) begin
      issue($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
            1'($urandom), 2'($urandom), "R3 R4 R8 mix");
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(4);
    if (sb.size() != 0) begin
      n_checks++;
      fail_line("R2", "results missing", sb.size(), 0);
    end
    finish_run();
  end
endmodule